// File: doc/BRIEF.md
# Exception Vector and Fault Sequencer

This control block sits beside the fetch and execute stages of a small processor core. It collects exception causes and decides which one the core services next. The causes are an odd-address instruction prefetch, divide by zero, a bounds-check failure, a conditional or overflow trap, a software trap with a 4-bit operand, a bus error and reset. For the chosen cause it presents the vector number and the byte offset of the vector. It also presents the new status word with supervisor mode set and tracing off, a copy of the old status word, the program counter to save and the fault address to save. The stacking unit receives a one-cycle start pulse and answers with a done pulse when the frame is written.

An odd prefetch is blocked at once through `fetch_suppress`. Its service waits until the in-flight instructions have retired, and any trap those instructions raise goes first. A bus error or an odd prefetch that arrives while a reset, bus-error or address-error sequence is still in progress is a double fault. The block then parks in a halted state, makes no further requests to the stacking unit, and leaves that state only through `rst_n`.

Top module: `exc_sequencer`

## Requirements
- R1: While `rst_n` is low, `halted`, `in_exc` and `stk_start` are 0. On the first rising edge with `rst_n` high, a reset sequence starts with `stk_start`=1, `vec_num`=0 and `sr_new`=0x2700.
- R2: When a sequence starts, `sr_saved` holds the `sr_in` of the decision cycle. For every cause except reset, `sr_new` equals that value with bit 13 (supervisor) set, bit 15 (T1) cleared and bit 14 (T0) cleared.
- R3: Divide by zero uses vector 5, bounds failure vector 6, conditional trap vector 7, and software trap n (0..15) vector 32+n. `vec_off` always equals 4 × `vec_num`.
- R4: For instruction traps, `pc_save` is the `next_pc` of the trap cycle and `fault_addr` is the `instr_addr` of that cycle.
- R5: A fetch with `fetch_addr[0]`=1 drives `fetch_suppress` high in the same cycle. Its later service uses vector 3, with `fault_addr` equal to the fetch address with bit 0 cleared and `pc_save` equal to the `instr_addr` seen with the fetch.
- R6: A pending address error does not start while `retire_busy` is 1.
- R7: An instruction trap in the same cycle as an eligible pending address error is serviced first. The address error starts on the cycle after that sequence ends.
- R8: Priority is reset, then a latched bus error, then instruction traps, then address error. Among traps the order is divide, bounds, conditional, software.
- R9: `stk_start` is high for exactly one cycle per sequence. `in_exc` stays 1 until `stk_done`, and trap requests that arrive while `in_exc` is 1 start nothing.
- R10: A bus error is latched and then serviced with vector 2, `fault_addr` = `bus_err_addr` and `pc_save` = `instr_addr`, both as seen with the error.
- R11: A bus error or odd fetch during a reset, bus-error or address-error sequence sets `halted`, clears `in_exc` and blocks all further starts until `rst_n` is low.
- R12: A bus error during an instruction-trap sequence is held and starts on the cycle after that sequence's `stk_done` has been taken, without halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the reset sequence |
| fetch_req | input | 1 | Instruction prefetch request, including a not-taken branch target |
| fetch_addr | input | AW | Prefetch address |
| instr_addr | input | AW | Address of the instruction currently being executed |
| next_pc | input | AW | Address of the instruction after the current one |
| retire_busy | input | 1 | In-flight instructions are still completing |
| req_div0 | input | 1 | Divide-by-zero trap |
| req_bounds | input | 1 | Bounds-check failure trap |
| req_cond | input | 1 | Conditional or overflow trap |
| req_swtrap | input | 1 | Software trap |
| swtrap_num | input | 4 | Software trap operand |
| bus_err | input | 1 | Bus error report |
| bus_err_addr | input | AW | Address of the failed access |
| sr_in | input | SRW | Current status word |
| stk_done | input | 1 | Stacking unit has finished the frame |
| fetch_suppress | output | 1 | Block the current prefetch bus cycle |
| stk_start | output | 1 | One-cycle start to the stacking unit |
| vec_num | output | 8 | Vector number |
| vec_off | output | 10 | Vector byte offset |
| sr_new | output | SRW | Status word to load |
| sr_saved | output | SRW | Status word to stack |
| pc_save | output | AW | Program counter to stack |
| fault_addr | output | AW | Fault address to stack |
| in_exc | output | 1 | A sequence is in progress |
| halted | output | 1 | Double fault; halted until reset |

## Verification
The assertions assume that `stk_done` comes only while `in_exc` is high and never in the same cycle as `stk_start`. They also assume that request inputs hold steady between clock edges. The bench drives every input on the falling edge, holds each request for a single cycle, and issues `stk_done` only on a cycle after the start pulse has been seen. It keeps bus errors away from the cycle in which a latched error is taken, so the ordering of each case is never ambiguous.

// File: rtl/exc_sequencer.sv
module exc_sequencer #(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_req,
  input  logic [AW-1:0]  fetch_addr,
  input  logic [AW-1:0]  instr_addr,
  input  logic [AW-1:0]  next_pc,
  input  logic           retire_busy,
  input  logic           req_div0,
  input  logic           req_bounds,
  input  logic           req_cond,
  input  logic           req_swtrap,
  input  logic [3:0]     swtrap_num,
  input  logic           bus_err,
  input  logic [AW-1:0]  bus_err_addr,
  input  logic [SRW-1:0] sr_in,
  input  logic           stk_done,
  output logic           fetch_suppress,
  output logic           stk_start,
  output logic [7:0]     vec_num,
  output logic [9:0]     vec_off,
  output logic [SRW-1:0] sr_new,
  output logic [SRW-1:0] sr_saved,
  output logic [AW-1:0]  pc_save,
  output logic [AW-1:0]  fault_addr,
  output logic           in_exc,
  output logic           halted
);
  localparam int S_BIT  = 13;
  localparam int T1_BIT = 15;
  localparam int T0_BIT = 14;
  localparam logic [SRW-1:0] RST_SR = SRW'(16'h2700);
  localparam logic [SRW-1:0] S_MASK = SRW'(1) << S_BIT;
  localparam logic [SRW-1:0] T_MASK = (SRW'(1) << T1_BIT) | (SRW'(1) << T0_BIT);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_HALT} state_t;
  typedef enum logic [1:0] {K_RST, K_BUS, K_ADDR, K_TRAP} kind_t;

  state_t st;
  kind_t  kind, n_kind;
  logic   rs_pend, be_pend, ae_pend, start_q;
  logic [AW-1:0]  be_addr, be_iaddr, ae_addr, ae_iaddr;
  logic [7:0]     vec_q, n_vec, trap_vec;
  logic [SRW-1:0] srn_q, srs_q, n_srn;
  logic [AW-1:0]  pc_q, fa_q, n_pc, n_fa;

  wire odd_fetch = fetch_req && fetch_addr[0];
  wire any_trap  = req_div0 | req_bounds | req_cond | req_swtrap;
  wire idle      = (st == ST_IDLE);
  wire critical  = (kind != K_TRAP);
  wire dbl       = (st == ST_ACT) && critical && (bus_err || odd_fetch);
  wire go_rst    = idle && rs_pend;
  wire go_bus    = idle && !rs_pend && be_pend;
  wire go_trap   = idle && !rs_pend && !be_pend && any_trap;
  wire go_addr   = idle && !rs_pend && !be_pend && !any_trap && ae_pend && !retire_busy;
  wire go_any    = go_rst | go_bus | go_trap | go_addr;
  wire [SRW-1:0] sr_mod = (sr_in | S_MASK) & ~T_MASK;

  assign fetch_suppress = odd_fetch;
  assign stk_start  = start_q;
  assign vec_num    = vec_q;
  assign vec_off    = {vec_q, 2'b00};
  assign sr_new     = srn_q;
  assign sr_saved   = srs_q;
  assign pc_save    = pc_q;
  assign fault_addr = fa_q;
  assign in_exc     = (st == ST_ACT);
  assign halted     = (st == ST_HALT);

  always_comb begin
    if (req_div0)        trap_vec = 8'd5;
    else if (req_bounds) trap_vec = 8'd6;
    else if (req_cond)   trap_vec = 8'd7;
    else                 trap_vec = {4'b0010, swtrap_num};
  end

  always_comb begin
    n_kind = K_TRAP;
    n_vec  = trap_vec;
    n_srn  = sr_mod;
    n_pc   = next_pc;
    n_fa   = instr_addr;
    if (go_rst) begin
      n_kind = K_RST;  n_vec = 8'd0; n_srn = RST_SR; n_pc = '0; n_fa = '0;
    end else if (go_bus) begin
      n_kind = K_BUS;  n_vec = 8'd2; n_pc = be_iaddr; n_fa = be_addr;
    end else if (go_addr) begin
      n_kind = K_ADDR; n_vec = 8'd3; n_pc = ae_iaddr; n_fa = {ae_addr[AW-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  kind <= K_RST;
      rs_pend <= 1'b1; be_pend <= 1'b0; ae_pend <= 1'b0; start_q <= 1'b0;
      be_addr <= '0; be_iaddr <= '0; ae_addr <= '0; ae_iaddr <= '0;
      vec_q <= '0; srn_q <= '0; srs_q <= '0; pc_q <= '0; fa_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (go_rst)  rs_pend <= 1'b0;
      if (go_bus)  be_pend <= 1'b0;
      if (go_addr) ae_pend <= 1'b0;
      if (bus_err && !dbl && st != ST_HALT) begin
        be_pend  <= 1'b1;
        be_addr  <= bus_err_addr;
        be_iaddr <= instr_addr;
      end
      if (odd_fetch && !ae_pend && !dbl && st != ST_HALT) begin
        ae_pend  <= 1'b1;
        ae_addr  <= fetch_addr;
        ae_iaddr <= instr_addr;
      end
      case (st)
        ST_IDLE: if (go_any) begin
          st <= ST_ACT;  kind <= n_kind;  start_q <= 1'b1;
          vec_q <= n_vec; srn_q <= n_srn; srs_q <= sr_in; pc_q <= n_pc; fa_q <= n_fa;
        end
        ST_ACT: begin
          if (dbl)           st <= ST_HALT;
          else if (stk_done) st <= ST_IDLE;
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_start |=> !stk_start);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_exc && !stk_done |=> in_exc || halted);
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !stk_start && !in_exc);
  assert_sr_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stk_start |-> sr_new[S_BIT] && !sr_new[T1_BIT] && !sr_new[T0_BIT]);
  assert_even_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_start && vec_num == 8'd3 |-> !fault_addr[0]);
  assert_retire_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_exc) && vec_num == 8'd3 |-> !$past(retire_busy));
endmodule

// File: tb/test_exc_sequencer.sv
`timescale 1ns/1ps
module test_exc_sequencer;
  localparam int AW = 32;
  localparam int SRW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 0, retire_busy = 0, req_div0 = 0, req_bounds = 0, req_cond = 0;
  logic req_swtrap = 0, bus_err = 0, stk_done = 0;
  logic [3:0] swtrap_num = '0;
  logic [AW-1:0] fetch_addr = '0, instr_addr = '0, next_pc = '0, bus_err_addr = '0;
  logic [SRW-1:0] sr_in = '0;
  logic fetch_suppress, stk_start, in_exc, halted;
  logic [7:0] vec_num;
  logic [9:0] vec_off;
  logic [SRW-1:0] sr_new, sr_saved;
  logic [AW-1:0] pc_save, fault_addr;

  int n_tests = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  exc_sequencer #(.AW(AW), .SRW(SRW)) i_exc_sequencer (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .instr_addr(instr_addr), .next_pc(next_pc), .retire_busy(retire_busy),
    .req_div0(req_div0), .req_bounds(req_bounds), .req_cond(req_cond),
    .req_swtrap(req_swtrap), .swtrap_num(swtrap_num), .bus_err(bus_err),
    .bus_err_addr(bus_err_addr), .sr_in(sr_in), .stk_done(stk_done),
    .fetch_suppress(fetch_suppress), .stk_start(stk_start), .vec_num(vec_num),
    .vec_off(vec_off), .sr_new(sr_new), .sr_saved(sr_saved), .pc_save(pc_save),
    .fault_addr(fault_addr), .in_exc(in_exc), .halted(halted));

  // {div0,bounds,cond,sw, n[3:0], sr_in[15:0], vec[7:0], sr_new[15:0]}
  localparam logic [47:0] TV [0:7] = '{
    {4'b1000, 4'h0, 16'hC000, 8'd5,  16'h2000},
    {4'b0100, 4'h0, 16'h001F, 8'd6,  16'h201F},
    {4'b0010, 4'h0, 16'h8700, 8'd7,  16'h2700},
    {4'b0001, 4'h0, 16'h4000, 8'd32, 16'h2000},
    {4'b0001, 4'hF, 16'hFFFF, 8'd47, 16'h3FFF},
    {4'b1111, 4'h9, 16'h0000, 8'd5,  16'h2000},
    {4'b0110, 4'h0, 16'hE000, 8'd6,  16'h2000},
    {4'b0011, 4'h3, 16'h2300, 8'd7,  16'h2300}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_reqs();
    fetch_req = 0; req_div0 = 0; req_bounds = 0; req_cond = 0; req_swtrap = 0; bus_err = 0;
  endtask

  task automatic finish_seq();
    stk_done = 1;
    @(negedge clk);
    stk_done = 0;
    check("R9 idle after done", in_exc, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    check("R1 halted in reset", halted, 0);
    check("R1 in_exc in reset", in_exc, 0);
    check("R1 start in reset", stk_start, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset start", stk_start, 1);
    check("R1 reset vector", vec_num, 0);
    check("R1 reset sr", sr_new, 16'h2700);
    finish_seq();
  endtask

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 8; i++) begin
      {req_div0, req_bounds, req_cond, req_swtrap} = TV[i][47:44];
      swtrap_num = TV[i][43:40];
      sr_in      = TV[i][39:24];
      next_pc    = 32'h100 + i * 16;
      instr_addr = 32'h200 + i * 16;
      @(negedge clk);
      clear_reqs();
      check("R9 trap start", stk_start, 1);
      check("R3 R8 trap vector", vec_num, TV[i][23:16]);
      check("R3 vector offset", vec_off, {TV[i][23:16], 2'b00});
      check("R2 new sr", sr_new, TV[i][15:0]);
      check("R2 saved sr", sr_saved, TV[i][39:24]);
      check("R4 saved pc", pc_save, 32'h100 + i * 16);
      check("R4 trap fault addr", fault_addr, 32'h200 + i * 16);
      @(negedge clk);
      check("R9 single pulse", stk_start, 0);
      finish_seq();
    end

    // R9: traps during a sequence are ignored
    sr_in = 16'h0000;
    req_div0 = 1;
    @(negedge clk);
    req_div0 = 0;
    check("R9 start", stk_start, 1);
    req_bounds = 1;
    @(negedge clk);
    req_bounds = 0;
    check("R9 busy ignores trap", stk_start, 0);
    check("R9 still busy", in_exc, 1);
    finish_seq();
    @(negedge clk);
    check("R9 dropped trap stays dropped", stk_start, 0);

    // R5 R6: address error waits for retire
    retire_busy = 1;
    fetch_req = 1; fetch_addr = 32'h1235; instr_addr = 32'h1230;
    #1 check("R5 suppress odd fetch", fetch_suppress, 1);
    @(negedge clk);
    fetch_req = 0; instr_addr = 32'h0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 held while retiring", stk_start, 0);
    end
    retire_busy = 0;
    @(negedge clk);
    check("R6 start after retire", stk_start, 1);
    check("R5 vector", vec_num, 3);
    check("R5 offset", vec_off, 12);
    check("R5 fault addr", fault_addr, 32'h1234);
    check("R5 saved pc", pc_save, 32'h1230);
    finish_seq();

    // R7: trap wins over pending address error
    retire_busy = 1;
    fetch_req = 1; fetch_addr = 32'h2001; instr_addr = 32'h1ff0;
    @(negedge clk);
    fetch_req = 0;
    retire_busy = 0; req_div0 = 1; next_pc = 32'h1ff4;
    @(negedge clk);
    req_div0 = 0;
    check("R7 trap first", vec_num, 5);
    check("R7 trap started", stk_start, 1);
    @(negedge clk);
    finish_seq();
    @(negedge clk);
    check("R7 address error follows", stk_start, 1);
    check("R7 address error vector", vec_num, 3);
    check("R7 address error fault", fault_addr, 32'h2000);
    finish_seq();

    // R8 R10: latched bus error beats a trap
    bus_err = 1; bus_err_addr = 32'h3000; instr_addr = 32'h2ff0;
    @(negedge clk);
    bus_err = 0; req_div0 = 1; instr_addr = 32'h0;
    @(negedge clk);
    req_div0 = 0;
    check("R8 bus beats trap", vec_num, 2);
    check("R10 bus fault addr", fault_addr, 32'h3000);
    check("R10 bus saved pc", pc_save, 32'h2ff0);
    finish_seq();

    // R12: bus error during trap sequence is deferred
    req_cond = 1;
    @(negedge clk);
    req_cond = 0;
    check("R12 trap start", vec_num, 7);
    bus_err = 1; bus_err_addr = 32'h4000;
    @(negedge clk);
    bus_err = 0;
    check("R12 no halt", halted, 0);
    finish_seq();
    @(negedge clk);
    check("R12 bus follows", stk_start, 1);
    check("R12 bus vector", vec_num, 2);
    check("R12 bus fault addr", fault_addr, 32'h4000);

    // R11: bus error during bus error sequence
    bus_err = 1; bus_err_addr = 32'h5000;
    @(negedge clk);
    bus_err = 0;
    check("R11 halted", halted, 1);
    check("R11 not busy", in_exc, 0);
    req_div0 = 1; stk_done = 1; fetch_req = 1; fetch_addr = 32'h11;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 no start when halted", stk_start, 0);
      check("R11 stays halted", halted, 1);
    end
    clear_reqs(); stk_done = 0;
    do_reset();
    check("R1 halt cleared", halted, 0);

    // R11: odd fetch during address error sequence
    fetch_req = 1; fetch_addr = 32'h6003;
    @(negedge clk);
    fetch_req = 0;
    @(negedge clk);
    check("R11 addr seq start", vec_num, 3);
    fetch_req = 1; fetch_addr = 32'h7001;
    @(negedge clk);
    fetch_req = 0;
    check("R11 odd fetch double fault", halted, 1);
    do_reset();

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule